// File: doc/BRIEF.md
# Signed-Amount Bidirectional Barrel Shifter

This block is a purely combinational 8-bit barrel shifter. A single signed shift field sets both the direction and the distance of the shift. It replaces a separate left-shift operation and a separate right-shift operation with one unit.

The field is a 4-bit two's-complement value. Its top bit is replicated to sign-extend it before use, so the field covers -8 to +7:

- A positive value moves the operand toward the most significant end.
- A negative value moves it toward the least significant end, by the magnitude of the value.
- Zero leaves the operand unchanged.

A mode input chooses the fill for right shifts. Logical mode fills with zeros. Arithmetic mode fills with copies of the operand's sign bit. A carry output returns the last bit that left the word.

Internally, a control module turns the raw field into a direction flag, a fill choice and an unsigned magnitude. A datapath module mirrors the operand for right shifts and runs it through a ladder of power-of-two shift stages. It then mirrors the result back.

Top module: `bidir_shifter`

## Requirements
- R1: With `shiftAmt` equal to 0, `resultOut` equals `opIn` and `carryOut` is 0, in either mode.
- R2: With `shiftAmt` in 1..7 (bit 3 clear), `resultOut` is `opIn` shifted toward bit 7 by that many places, and the vacated low bits are 0.
- R3: With bit 3 of `shiftAmt` set, the field is read as a negative number (value minus 16), and `resultOut` is `opIn` shifted toward bit 0 by its magnitude (1..8).
- R4: In logical mode (`arithMode` = 0), the bits vacated at the top by a right shift are 0.
- R5: In arithmetic mode (`arithMode` = 1), the bits vacated at the top by a right shift equal `opIn[7]`.
- R6: On a left shift by n, `carryOut` equals `opIn[8-n]`.
- R7: On a right shift by m, `carryOut` equals `opIn[m-1]`.
- R8: With `shiftAmt` = 4'b1000 (-8), `resultOut` is 0 in logical mode and eight copies of `opIn[7]` in arithmetic mode, and `carryOut` equals `opIn[7]`.
- R9: `arithMode` has no effect on `resultOut` or `carryOut` when `shiftAmt` is zero or positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opIn | input | 8 | Operand to be shifted |
| shiftAmt | input | 4 | Signed shift field; sign gives direction, magnitude gives distance |
| arithMode | input | 1 | 1 selects sign fill on right shifts, 0 selects zero fill |
| resultOut | output | 8 | Shifted operand |
| carryOut | output | 1 | Last bit shifted out; 0 when no shift happens |

## Verification
The assertions check the following on every input change:
- zero-amount pass-through;
- zero fill of the low bits on left shifts;
- zero or sign fill of the top bits on right shifts;
- the carry bit for both directions;
- the -8 extreme.

These are all conditions that a mask over the ports can express. The exact placement of every surviving operand bit can only be shown by the bench's scenarios, which compare full results against an independent arithmetic model. The same applies to the full sweep of every operand, amount and mode. So does the absence of any mode effect on left shifts, which the bench shows by comparing paired results.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  // Widest magnitude the control path can carry to the datapath.
  localparam int SHF_MAG_W = 8;

  typedef struct packed {
    logic                 goRight;    // shift toward bit 0
    logic                 arithFill;  // replicate sign on right shift
    logic [SHF_MAG_W-1:0] magnitude;  // unsigned distance
  } shift_ctrl_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
#(
  parameter int AMT_W = 4
) (
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             arithMode,
  output shift_ctrl_t      ctrlOut
);
  localparam int EXT_W = AMT_W + 1;

  logic             isNeg;
  logic [EXT_W-1:0] extAmt;
  logic [EXT_W-1:0] negAmt;
  logic [EXT_W-1:0] magExt;

  always_comb begin
    isNeg  = shiftAmt[AMT_W-1];
    // sign-extend by one bit so that the most negative value can be negated
    extAmt = {shiftAmt[AMT_W-1], shiftAmt};
    negAmt = (~extAmt) + EXT_W'(1);
    magExt = isNeg ? negAmt : extAmt;

    ctrlOut           = '0;
    ctrlOut.goRight   = isNeg;
    ctrlOut.arithFill = isNeg & arithMode;
    ctrlOut.magnitude = SHF_MAG_W'(magExt);
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAGES = 4
) (
  input  logic [DATA_W-1:0] opIn,
  input  shift_ctrl_t       ctrlIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut
);
  localparam int WORK_W = DATA_W + 1;

  logic [DATA_W-1:0] mirrorIn;
  logic [DATA_W-1:0] mirrorOut;
  logic              fillBit;
  logic [WORK_W-1:0] stageVec [STAGES+1];

  // Mirror the operand so a right shift becomes a left shift.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror_in
    assign mirrorIn[i] = ctrlIn.goRight ? opIn[DATA_W-1-i] : opIn[i];
  end

  assign fillBit     = ctrlIn.arithFill & opIn[DATA_W-1];
  assign stageVec[0] = {1'b0, mirrorIn};

  // Stage k moves the working word up by 2**k places when magnitude bit k is set.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int DIST = 1 << k;
    for (genvar i = 0; i < WORK_W; i++) begin : g_bit
      if (i >= DIST) begin : g_take
        assign stageVec[k+1][i] = ctrlIn.magnitude[k] ? stageVec[k][i-DIST] : stageVec[k][i];
      end else begin : g_fill
        assign stageVec[k+1][i] = ctrlIn.magnitude[k] ? fillBit : stageVec[k][i];
      end
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror_out
    assign mirrorOut[i] = ctrlIn.goRight ? stageVec[STAGES][DATA_W-1-i] : stageVec[STAGES][i];
  end

  assign resultOut = mirrorOut;
  assign carryOut  = stageVec[STAGES][DATA_W];

  // Magnitude bits above the stage ladder are never set for legal parameters.
  logic unusedMag;
  assign unusedMag = ^ctrlIn.magnitude;
endmodule

// File: rtl/bidir_shifter.sv
module bidir_shifter
  import shifter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int AMT_W  = 4
) (
  input  logic [DATA_W-1:0] opIn,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic              arithMode,
  output logic [DATA_W-1:0] resultOut,
  output logic              carryOut
);
  // A magnitude of up to 2**(AMT_W-1) needs AMT_W stages.
  localparam int STAGES = AMT_W;

  shift_ctrl_t ctrlBus;

  shift_ctrl #(.AMT_W(AMT_W)) u_ctrl (
    .shiftAmt (shiftAmt),
    .arithMode(arithMode),
    .ctrlOut  (ctrlBus)
  );

  shift_datapath #(.DATA_W(DATA_W), .STAGES(STAGES)) u_dp (
    .opIn     (opIn),
    .ctrlIn   (ctrlBus),
    .resultOut(resultOut),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/shifter_chk.sv
module shifter_chk #(
  parameter int DATA_W = 8,
  parameter int AMT_W  = 4
) (
  input logic [DATA_W-1:0] opIn,
  input logic [AMT_W-1:0]  shiftAmt,
  input logic              arithMode,
  input logic [DATA_W-1:0] resultOut,
  input logic              carryOut
);
  localparam int MIN_AMT = 1 << (AMT_W - 1);

  always_comb begin
    int amtVal;
    logic [DATA_W-1:0] lowMask;
    logic [DATA_W-1:0] highMask;

    amtVal   = shiftAmt[AMT_W-1] ? int'(shiftAmt) - (1 << AMT_W) : int'(shiftAmt);
    lowMask  = '0;
    highMask = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (amtVal > 0 && i < amtVal) lowMask[i] = 1'b1;
      if (amtVal < 0 && i >= DATA_W + amtVal) highMask[i] = 1'b1;
    end

    if (amtVal == 0) begin
      AST_ZERO_PASS: assert (resultOut == opIn && carryOut == 1'b0); // R1
    end
    if (amtVal > 0) begin
      AST_LEFT_LOW_ZERO: assert ((resultOut & lowMask) == '0); // R2
      AST_LEFT_CARRY: assert (carryOut == opIn[DATA_W-amtVal]); // R6
    end
    if (amtVal < 0 && !arithMode) begin
      AST_RIGHT_ZERO_FILL: assert ((resultOut & highMask) == '0); // R4
    end
    if (amtVal < 0 && arithMode) begin
      AST_RIGHT_SIGN_FILL: assert ((resultOut & highMask) == (opIn[DATA_W-1] ? highMask : '0)); // R5
    end
    if (amtVal < 0) begin
      AST_RIGHT_CARRY: assert (carryOut == opIn[-amtVal-1]); // R7
    end
    if (amtVal == -MIN_AMT && MIN_AMT == DATA_W) begin
      AST_MIN_AMOUNT: assert (resultOut == ((arithMode && opIn[DATA_W-1]) ? '1 : '0)); // R8
    end
  end
endmodule

bind bidir_shifter shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .opIn     (opIn),
  .shiftAmt (shiftAmt),
  .arithMode(arithMode),
  .resultOut(resultOut),
  .carryOut (carryOut)
);

// File: tb/sim_bidir_shifter.sv
module sim_bidir_shifter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opIn = '0;
  logic [3:0] shiftAmt = '0;
  logic       arithMode = 1'b0;
  logic [7:0] resultOut;
  logic       carryOut;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;
  bit finished   = 1'b0;

  always #5 clk = ~clk;

  bidir_shifter u0 (
    .opIn     (opIn),
    .shiftAmt (shiftAmt),
    .arithMode(arithMode),
    .resultOut(resultOut),
    .carryOut (carryOut)
  );

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 60000 && !finished) begin
      failCount = failCount + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected completion", cycleCount);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  // Independent arithmetic model of the requirements.
  function automatic logic [8:0] model(input logic [7:0] op, input logic [3:0] amt, input logic ar);
    int        v;
    logic [15:0] wide;
    logic [7:0]  res;
    logic        cy;
    v = amt[3] ? int'(amt) - 16 : int'(amt);
    if (v == 0) begin
      res = op; cy = 1'b0;
    end else if (v > 0) begin
      wide = {8'h00, op} << v;
      res = wide[7:0]; cy = wide[8];
    end else begin
      wide = {((ar && op[7]) ? 8'hFF : 8'h00), op} >> (-v);
      res = wide[7:0]; cy = op[-v-1];
    end
    return {cy, res};
  endfunction

  task automatic apply(input logic [7:0] op, input logic [3:0] amt, input logic ar);
    @(negedge clk);
    opIn = op; shiftAmt = amt; arithMode = ar;
    #2;
  endtask

  task automatic check(input string tag, input logic [8:0] exp);
    checkCount++;
    if ({carryOut, resultOut} !== exp) begin
      failCount++;
      $display("FAIL %s: op=%h amt=%h mode=%b got res=%h cy=%b expected res=%h cy=%b",
               tag, opIn, shiftAmt, arithMode, resultOut, carryOut, exp[7:0], exp[8]);
    end
  endtask

  task automatic t_reset_state();
    apply(8'h00, 4'h0, 1'b0);
    check("R1 reset state", 9'h000);
  endtask

  task automatic t_zero_pass();
    apply(8'hA5, 4'h0, 1'b0); check("R1 zero amount logical", {1'b0, 8'hA5});
    apply(8'hC3, 4'h0, 1'b1); check("R1 zero amount arith", {1'b0, 8'hC3});
  endtask

  task automatic t_left();
    apply(8'h81, 4'd1, 1'b0); check("R2 R6 left by 1", {1'b1, 8'h02});
    apply(8'h0F, 4'd4, 1'b0); check("R2 R6 left by 4", {1'b0, 8'hF0});
    apply(8'h03, 4'd7, 1'b0); check("R2 R6 left by 7", {1'b1, 8'h80});
  endtask

  task automatic t_right_logical();
    apply(8'h81, 4'hF, 1'b0); check("R3 R4 R7 logical right by 1", {1'b1, 8'h40});
    apply(8'hF0, 4'hC, 1'b0); check("R3 R4 R7 logical right by 4", {1'b0, 8'h0F});
  endtask

  task automatic t_right_arith();
    apply(8'h90, 4'hE, 1'b1); check("R3 R5 R7 arith right by 2 neg", {1'b0, 8'hE4});
    apply(8'h7C, 4'hD, 1'b1); check("R3 R5 R7 arith right by 3 pos", {1'b1, 8'h0F});
    apply(8'h80, 4'h9, 1'b1); check("R3 R5 R7 arith right by 7", {1'b0, 8'hFF});
  endtask

  task automatic t_min_amount();
    apply(8'hB6, 4'h8, 1'b0); check("R8 minus eight logical", {1'b1, 8'h00});
    apply(8'hB6, 4'h8, 1'b1); check("R8 minus eight arith neg", {1'b1, 8'hFF});
    apply(8'h36, 4'h8, 1'b1); check("R8 minus eight arith pos", {1'b0, 8'h00});
  endtask

  task automatic t_mode_no_effect();
    for (int a = 0; a < 8; a++) begin
      logic [8:0] first;
      apply(8'hD9, 4'(a), 1'b0);
      first = {carryOut, resultOut};
      apply(8'hD9, 4'(a), 1'b1);
      check("R9 mode ignored on non-negative amount", first);
    end
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 256; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int m = 0; m < 2; m++) begin
          apply(8'(op), 4'(a), 1'(m));
          if (a == 0)      check("R1 sweep", model(8'(op), 4'(a), 1'(m)));
          else if (a < 8)  check("R2 R6 sweep", model(8'(op), 4'(a), 1'(m)));
          else             check("R3 R7 sweep", model(8'(op), 4'(a), 1'(m)));
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    t_reset_state();
    t_zero_pass();
    t_left();
    t_right_logical();
    t_right_arith();
    t_min_amount();
    t_mode_no_effect();
    t_sweep();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule